// File: doc/BRIEF.md
# Stereo One-Bit Noise-Shaping Modulator

This block turns a stereo pair of oversampled PCM words into two one-bit pulse-density streams that run at the full master-clock rate. Upstream logic supplies a new left/right pair at eight times the base sample rate. The modulator runs at 384 times the base rate, so each captured pair stays in use for a fixed 48 master clocks. An internal phase counter marks the capture cycle with a one-cycle strobe, which also serves as the request for the next pair.

Each channel has an error-feedback noise shaper (second order by default, first order as an option) and a sign quantizer. The shaper pushes quantization error away from the audio band. Its error memories saturate at a parameterised bound, so the loop stays stable when the input sits close to full scale. Each channel drives a complementary pin pair, A and B, for a differential reconstruction filter outside the block.

While the synchronous active-low reset is asserted, the shaper memories and the held samples are cleared. Output A then alternates on every clock and B mirrors it inverted, which is a 50% density and represents analog zero.

Top module: `ns_onebit_dac`

## Requirements
- R1: `sample_take` is high for exactly one cycle out of every 48. It first goes high in the first cycle after the first rising edge that sees `rst_n` high. `din_l` and `din_r` are captured at the rising edge that ends each `sample_take` cycle.
- R2: A value on `din_l` or `din_r` in any cycle where `sample_take` is low has no effect on the output streams.
- R3: For a held two's-complement input x (16 bits, full scale 32768), the fraction of ones on output A over 20 hold periods (960 clocks) is (1 + x/32768)/2, within ±30 ones.
- R4: On every clock, output B of a channel is the inverse of output A of that channel. This holds in reset and in normal operation.
- R5: While `rst_n` is low, output A of each channel inverts on every clock and `sample_take` stays low. Reset clears the shaper memories and held samples, so a zero input after release gives a density of 480 ± 30 ones per 960 clocks.
- R6: At full-scale input (+32767 or −32768) the loop stays bounded. The error memories never leave ±65536, and the density is within 30 ones of 960 or of 0 respectively.
- R7: The left and right channels are independent. Each channel's density follows its own input when the two inputs differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master modulator clock, 384x base rate |
| rst_n | input | 1 | Synchronous active-low reset |
| din_l | input | 16 | Left sample, two's complement |
| din_r | input | 16 | Right sample, two's complement |
| sample_take | output | 1 | Capture strobe, one cycle per 48 |
| out_l_a | output | 1 | Left stream, true polarity |
| out_l_b | output | 1 | Left stream, inverted polarity |
| out_r_a | output | 1 | Right stream, true polarity |
| out_r_b | output | 1 | Right stream, inverted polarity |

## Verification
The capture strobe and a change of the input words can fall in the same cycle. The bench presents the true sample only during the cycle in which `sample_take` is seen high. In every other cycle it drives the bitwise inverse, so the wrong value stands on the pins right next to each capture edge. The measured density must then match the true value and not the inverse. Reset is also asserted in the middle of a run while the loop holds non-zero memories. The bench judges the alternating pattern, the complement pair and the 50% density that follows release.

// File: rtl/ns_onebit_pkg.sv
package ns_onebit_pkg;
   localparam int CHANNELS = 2;

   // accumulator width for the shaper: data + saturation headroom + sum growth
   function automatic int shaper_acc_width(input int data_w, input int lim_shift);
      return data_w + lim_shift + 3;
   endfunction
endpackage

// File: rtl/hold_timer.sv
module hold_timer #(
   parameter int HOLD_CYCLES = 48
) (
   input  logic clk,
   input  logic rst_n,
   output logic take
);
   localparam int PH_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(HOLD_CYCLES - 1);

   logic [PH_W-1:0] phase_q;
   logic            run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         run_q   <= 1'b0;
      end else begin
         run_q <= 1'b1;
         if (run_q) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
         end
      end
   end

   assign take = run_q && (phase_q == '0);

   p_take_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take)
      else $error("capture strobe longer than one cycle");
endmodule

// File: rtl/sample_hold.sv
module sample_hold #(
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take,
   input  logic signed [DATA_W-1:0] din,
   output logic signed [DATA_W-1:0] held
);
   always_ff @(posedge clk) begin
      if (!rst_n)    held <= '0;
      else if (take) held <= din;
   end

   p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(take) |-> $stable(held))
      else $error("held sample moved without a capture strobe");
endmodule

// File: rtl/ef_shaper.sv
module ef_shaper #(
   parameter int DATA_W    = 16,
   parameter int ORDER     = 2,
   parameter int LIM_SHIFT = 1,
   parameter int ACC_W     = DATA_W + LIM_SHIFT + 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] sample,
   output logic                     bit_q
);
   localparam logic signed [ACC_W-1:0] FS =
      {{(ACC_W-DATA_W){1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] LIM     = FS <<< LIM_SHIFT;
   localparam logic signed [ACC_W-1:0] NEG_LIM = -LIM;
   localparam logic signed [ACC_W-1:0] NEG_FS  = -FS;

   logic signed [ACC_W-1:0] x_ext, u, fb, e_raw, e_sat, e1_q;
   logic                    bit_d;

   assign x_ext = {{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample};

   generate
      if (ORDER == 2) begin : g_second
         logic signed [ACC_W-1:0] e2_q;
         always_ff @(posedge clk) begin
            if (!rst_n) e2_q <= '0;
            else        e2_q <= e1_q;
         end
         // NTF (1 - z^-1)^2
         assign u = x_ext + (e1_q <<< 1) - e2_q;
      end else begin : g_first
         // NTF (1 - z^-1)
         assign u = x_ext + e1_q;
      end
   endgenerate

   assign bit_d = ~u[ACC_W-1];
   assign fb    = bit_d ? FS : NEG_FS;
   assign e_raw = u - fb;

   always_comb begin
      if (e_raw > LIM)          e_sat = LIM;
      else if (e_raw < NEG_LIM) e_sat = NEG_LIM;
      else                      e_sat = e_raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e1_q  <= '0;
         bit_q <= 1'b0;
      end else begin
         e1_q  <= e_sat;
         bit_q <= bit_d;
      end
   end

   p_err_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (e1_q <= LIM) && (e1_q >= NEG_LIM))
      else $error("shaper memory outside saturation bound");
endmodule

// File: rtl/pair_out.sv
module pair_out (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_i,
   output logic out_a,
   output logic out_b
);
   logic next_a;
   logic primed_q;
   logic rst_lo_q;

   assign next_a = rst_n ? bit_i : ~out_a;

   always_ff @(posedge clk) begin
      out_a    <= next_a;
      out_b    <= ~next_a;
      primed_q <= 1'b1;
      rst_lo_q <= ~rst_n;
   end

   p_pair_complement_r4: assert property (@(posedge clk)
      primed_q |-> (out_a != out_b))
      else $error("differential pair not complementary");

   p_reset_toggle_r5: assert property (@(posedge clk)
      (primed_q && rst_lo_q) |-> (out_a != $past(out_a)))
      else $error("output did not alternate during reset");
endmodule

// File: rtl/ns_onebit_dac.sv
module ns_onebit_dac
   import ns_onebit_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int HOLD_CYCLES = 48,
   parameter int ORDER       = 2,
   parameter int LIM_SHIFT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din_l,
   input  logic [DATA_W-1:0] din_r,
   output logic              sample_take,
   output logic              out_l_a,
   output logic              out_l_b,
   output logic              out_r_a,
   output logic              out_r_b
);
   localparam int ACC_W = shaper_acc_width(DATA_W, LIM_SHIFT);

   generate
      if (DATA_W < 8 || DATA_W > 24)
         $error("DATA_W must lie in 8..24");
      if (HOLD_CYCLES < 2)
         $error("HOLD_CYCLES must be at least 2");
      if (ORDER != 1 && ORDER != 2)
         $error("ORDER must be 1 or 2");
      if (LIM_SHIFT < 1 || LIM_SHIFT > 3)
         $error("LIM_SHIFT must lie in 1..3");
   endgenerate

   logic signed [DATA_W-1:0] din_arr [CHANNELS];
   logic [CHANNELS-1:0]      a_vec, b_vec;

   assign din_arr[0] = din_l;
   assign din_arr[1] = din_r;

   hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .take (sample_take)
   );

   generate
      for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
         logic signed [DATA_W-1:0] held;
         logic                     qbit;

         sample_hold #(.DATA_W(DATA_W)) u_hold (
            .clk  (clk),
            .rst_n(rst_n),
            .take (sample_take),
            .din  (din_arr[ch]),
            .held (held)
         );

         ef_shaper #(
            .DATA_W   (DATA_W),
            .ORDER    (ORDER),
            .LIM_SHIFT(LIM_SHIFT),
            .ACC_W    (ACC_W)
         ) u_shaper (
            .clk   (clk),
            .rst_n (rst_n),
            .sample(held),
            .bit_q (qbit)
         );

         pair_out u_pair (
            .clk  (clk),
            .rst_n(rst_n),
            .bit_i(qbit),
            .out_a(a_vec[ch]),
            .out_b(b_vec[ch])
         );
      end
   endgenerate

   assign out_l_a = a_vec[0];
   assign out_l_b = b_vec[0];
   assign out_r_a = a_vec[1];
   assign out_r_b = b_vec[1];
endmodule

// File: tb/test_ns_onebit_dac.sv
module test_ns_onebit_dac;
   localparam int HOLD   = 48;
   localparam int WIN    = 20 * HOLD;
   localparam int TOL    = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] din_l = '0, din_r = '0;
   logic        sample_take, out_l_a, out_l_b, out_r_a, out_r_b;

   int cur_l = 0, cur_r = 0;
   bit scramble = 1'b0;
   int n_checks = 0, n_fail = 0;

   typedef struct { string tag; int exp_l; int exp_r; } item_t;
   item_t sb_q[$];

   always #5 clk = ~clk;

   ns_onebit_dac i_ns_onebit_dac (
      .clk(clk), .rst_n(rst_n), .din_l(din_l), .din_r(din_r),
      .sample_take(sample_take),
      .out_l_a(out_l_a), .out_l_b(out_l_b),
      .out_r_a(out_r_a), .out_r_b(out_r_b)
   );

   // stimulus feeder: true value only in the capture cycle when scrambling
   always @(negedge clk) begin
      if (sample_take || !scramble) begin
         din_l <= 16'(cur_l);
         din_r <= 16'(cur_r);
      end else begin
         din_l <= ~16'(cur_l);
         din_r <= ~16'(cur_r);
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int density(input int v);
      return (WIN / 2) + (v * (WIN / 2)) / 32768;
   endfunction

   // driver: set inputs, let the loop settle, queue the expected densities
   task automatic run_window(input string tag, input int vl, input int vr,
                             input bit scr);
      cur_l = vl;
      cur_r = vr;
      scramble = scr;
      repeat (3 * HOLD) @(negedge clk);
      sb_q.push_back('{tag, density(vl), density(vr)});
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   // monitor: count ones over whole hold periods and compare with the queue
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() != 0) begin
            item_t it;
            int ones_l, ones_r;
            bit pair_ok;
            ones_l = 0; ones_r = 0; pair_ok = 1'b1;
            while (!sample_take) @(negedge clk);
            for (int i = 0; i < WIN; i++) begin
               ones_l += int'(out_l_a);
               ones_r += int'(out_r_a);
               if (out_l_a == out_l_b || out_r_a == out_r_b) pair_ok = 1'b0;
               @(negedge clk);
            end
            it = sb_q.pop_front();
            check(ones_l >= it.exp_l - TOL && ones_l <= it.exp_l + TOL,
                  it.tag, "left density", ones_l, it.exp_l);
            check(ones_r >= it.exp_r - TOL && ones_r <= it.exp_r + TOL,
                  it.tag, "right density", ones_r, it.exp_r);
            check(pair_ok, "R4", "B inverse of A in window", int'(pair_ok), 1);
         end
      end
   end

   task automatic reset_phase(input int cycles);
      bit ok;
      logic pl, pr;
      ok = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      pl = out_l_a; pr = out_r_a;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (out_l_a == pl || out_r_a == pr) ok = 1'b0;
         if (out_l_a == out_l_b || out_r_a == out_r_b) ok = 1'b0;
         if (sample_take) ok = 1'b0;
         pl = out_l_a; pr = out_r_a;
      end
      // R5: alternation, R4: complement in reset
      check(ok, "R5", "reset alternation and pair", int'(ok), 1);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int gap;
      @(negedge clk);
      reset_phase(12);
      @(negedge clk);
      check(sample_take == 1'b1, "R1", "first strobe after release",
            int'(sample_take), 1);
      for (int k = 0; k < 3; k++) begin
         gap = 0;
         do begin
            @(negedge clk);
            gap++;
         end while (!sample_take && gap < 200);
         check(gap == HOLD, "R1", "strobe spacing", gap, HOLD);
      end

      run_window("R5", 0, 0, 1'b0);              // zero after reset, cleared state
      run_window("R3", 16384, -16384, 1'b0);     // +half / -half
      run_window("R3", -8192, 24576, 1'b0);
      run_window("R7", 12000, -20000, 1'b0);     // independent channels
      run_window("R2", 8192, -12288, 1'b1);      // inverse between captures
      run_window("R6", 32767, -32768, 1'b0);     // full scale
      run_window("R6", -32768, 32767, 1'b0);

      // mid-run reset with non-zero memories
      cur_l = 20000; cur_r = -20000;
      repeat (200) @(negedge clk);
      reset_phase(10);
      cur_l = 0; cur_r = 0;
      run_window("R5", 0, 0, 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule